// File: doc/BRIEF.md
# UART Software Flow-Control Detector

This block sits between a UART receiver and its receive FIFO. It inspects each received byte for in-band pause and resume characters, and it gates the local transmitter to match. The host programs four pattern registers: two for resume and two for pause. It also sets an enable bit, a mode bit that selects one-byte or two-byte patterns, and an option that lets any received byte restart a paused transmitter.

Bytes that form a pause or resume pattern are taken out of the data stream. All other bytes are passed on, in arrival order, as a one-cycle strobe toward the FIFO. A pause takes effect only when the transmitter reports a character boundary, so a character that is already being shifted out still finishes. Each pattern detection raises a one-cycle event pulse for the interrupt logic.

In two-byte mode, a byte that matches a first pattern is held back until the next byte arrives. If that next byte does not complete the pattern, the held byte is released as data. The new byte is then judged again as a possible first byte.

Top module: `swfc_detect`

## Requirements
- R1: After the synchronous reset, `tx_enable` is 1, and `fwd_valid`, `evt_pause` and `evt_resume` are 0.
- R2: While `cfg_enable` is 0, every received byte appears on `fwd_data` with `fwd_valid` high one cycle after its strobe. No event pulses occur and `tx_enable` stays 1.
- R3: In one-byte mode (`cfg_double`=0) only `cfg_pause_a` and `cfg_resume_a` are compared. A byte equal to `cfg_pause_a` is dropped and raises `evt_pause` one cycle later. A byte equal to `cfg_resume_a` is dropped and raises `evt_resume`. A byte equal only to a second pattern is forwarded. When both first patterns are equal, pause wins.
- R4: In two-byte mode, two consecutive bytes equal to the first and then the second value of a pair form a detection. Neither byte is forwarded, and the event pulses one cycle after the second byte.
- R5: In two-byte mode, a held first byte followed by a byte that does not complete its pair is forwarded one cycle after that byte. If the new byte is not a first pattern, it is forwarded on the following cycle. If it is a first pattern, it is held instead.
- R6: After a pause detection, `tx_enable` falls in the first cycle in which `tx_boundary` is sampled high, counting from the detecting edge. It never falls at any other time.
- R7: A resume detection sets `tx_enable` to 1 one cycle after the completing byte.
- R8: While paused with `cfg_any_resume`=1, any received byte resumes the transmitter one cycle later, and a byte that is not part of a pattern is still forwarded. With `cfg_any_resume`=0, a plain data byte leaves the transmitter paused.
- R9: Clearing `cfg_enable` sets `tx_enable` to 1 on the next cycle and discards any held first byte. The held byte is never forwarded.
- R10: `evt_pause` and `evt_resume` are never high together, and each is high for one cycle only.
- R11: The received-byte strobe `rx_valid` is never high on two consecutive cycles. The block assumes this spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Software flow control on |
| cfg_double | input | 1 | 1: two-byte patterns, 0: one-byte patterns |
| cfg_any_resume | input | 1 | Any received byte resumes a paused transmitter |
| cfg_resume_a | input | W | First resume pattern |
| cfg_resume_b | input | W | Second resume pattern |
| cfg_pause_a | input | W | First pause pattern |
| cfg_pause_b | input | W | Second pause pattern |
| rx_valid | input | 1 | Received-byte strobe |
| rx_data | input | W | Received byte |
| tx_boundary | input | 1 | Transmitter idle or between characters |
| tx_enable | output | 1 | Transmit permission |
| fwd_valid | output | 1 | Strobe for a data byte toward the receive FIFO |
| fwd_data | output | W | Forwarded data byte |
| evt_pause | output | 1 | One-cycle pulse on pause detection |
| evt_resume | output | 1 | One-cycle pulse on resume detection |

## Verification
The assertions check, on every cycle, the following:
- the spacing of the input strobe;
- that `tx_enable` only falls at a sampled boundary and rises whenever flow control is off;
- that the event pulses are exclusive and one cycle long;
- that a pause detection never coincides with a forwarded byte;
- that no byte is held outside two-byte mode.

Only the bench's scenarios can show the rest:
- which bytes are forwarded and in what order, including the two-cycle release after a broken pair;
- that second patterns are ignored in one-byte mode;
- that pause takes priority over resume;
- the difference between any-byte resume and programmed resume;
- that a held byte disappears when flow control is switched off.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
  // Per-byte comparison results against the four programmed patterns
  typedef struct packed {
    logic resume_a;
    logic resume_b;
    logic pause_a;
    logic pause_b;
  } hit_t;
endpackage

// File: rtl/swfc_match.sv
module swfc_match
  import swfc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] byte_in,
  input  logic [W-1:0] resume_a,
  input  logic [W-1:0] resume_b,
  input  logic [W-1:0] pause_a,
  input  logic [W-1:0] pause_b,
  output hit_t         hit
);
  always_comb begin
    hit.resume_a = (byte_in == resume_a);
    hit.resume_b = (byte_in == resume_b);
    hit.pause_a  = (byte_in == pause_a);
    hit.pause_b  = (byte_in == pause_b);
  end
endmodule

// File: rtl/swfc_seq.sv
module swfc_seq
  import swfc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_enable,
  input  logic         cfg_double,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_data,
  input  hit_t         hit,
  output logic         lane0_v,
  output logic [W-1:0] lane0_d,
  output logic         lane1_v,
  output logic [W-1:0] lane1_d,
  output logic         det_pause,
  output logic         det_resume
);
  logic         hold_v, hold_on, hold_off;
  logic [W-1:0] hold_d;
  logic         nh_v, nh_on, nh_off;
  logic [W-1:0] nh_d;
  logic         first_hit;

  assign first_hit = hit.resume_a | hit.pause_a;

  always_comb begin
    lane0_v    = 1'b0;
    lane0_d    = '0;
    lane1_v    = 1'b0;
    lane1_d    = '0;
    det_pause  = 1'b0;
    det_resume = 1'b0;
    nh_v       = hold_v;
    nh_d       = hold_d;
    nh_on      = hold_on;
    nh_off     = hold_off;
    if (!cfg_enable || !cfg_double) begin
      nh_v   = 1'b0;
      nh_on  = 1'b0;
      nh_off = 1'b0;
      if (rx_valid) begin
        if (cfg_enable && hit.pause_a)       det_pause  = 1'b1;
        else if (cfg_enable && hit.resume_a) det_resume = 1'b1;
        else begin
          lane0_v = 1'b1;
          lane0_d = rx_data;
        end
      end
    end else if (rx_valid) begin
      if (hold_v && hold_off && hit.pause_b) begin
        det_pause = 1'b1;
        nh_v      = 1'b0;
      end else if (hold_v && hold_on && hit.resume_b) begin
        det_resume = 1'b1;
        nh_v       = 1'b0;
      end else begin
        if (hold_v) begin
          lane0_v = 1'b1;
          lane0_d = hold_d;
        end
        if (first_hit) begin
          nh_v   = 1'b1;
          nh_d   = rx_data;
          nh_on  = hit.resume_a;
          nh_off = hit.pause_a;
        end else begin
          nh_v = 1'b0;
          if (hold_v) begin
            lane1_v = 1'b1;
            lane1_d = rx_data;
          end else begin
            lane0_v = 1'b1;
            lane0_d = rx_data;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v   <= 1'b0;
      hold_on  <= 1'b0;
      hold_off <= 1'b0;
      hold_d   <= '0;
    end else begin
      hold_v   <= nh_v;
      hold_on  <= nh_on;
      hold_off <= nh_off;
      hold_d   <= nh_d;
    end
  end

  // R3 / R9: no byte is held outside enabled two-byte mode
  assert_no_hold_single_R3: assert property (@(posedge clk) disable iff (rst)
    (!cfg_double || !cfg_enable) |=> !hold_v);
  // R5: a byte that breaks a pair releases the held byte on the first lane
  assert_flush_held_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg_enable && cfg_double && hold_v && rx_valid && !det_pause && !det_resume)
      |-> (lane0_v && lane0_d == hold_d));
endmodule

// File: rtl/swfc_gate.sv
module swfc_gate (
  input  logic clk,
  input  logic rst,
  input  logic cfg_enable,
  input  logic cfg_any_resume,
  input  logic rx_valid,
  input  logic det_pause,
  input  logic det_resume,
  input  logic tx_boundary,
  output logic tx_enable,
  output logic evt_pause,
  output logic evt_resume
);
  logic halt_q, halt_d, txen_d;

  always_comb begin
    if (!cfg_enable)                              halt_d = 1'b0;
    else if (det_pause)                           halt_d = 1'b1;
    else if (det_resume || (cfg_any_resume && rx_valid)) halt_d = 1'b0;
    else                                          halt_d = halt_q;

    if (!halt_d)          txen_d = 1'b1;
    else if (tx_boundary) txen_d = 1'b0;
    else                  txen_d = tx_enable;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q     <= 1'b0;
      tx_enable  <= 1'b1;
      evt_pause  <= 1'b0;
      evt_resume <= 1'b0;
    end else begin
      halt_q     <= halt_d;
      tx_enable  <= txen_d;
      evt_pause  <= det_pause;
      evt_resume <= det_resume;
    end
  end

  // R6: transmission stops only at a sampled character boundary
  assert_stop_at_boundary_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_enable) |-> $past(tx_boundary));
  // R9: flow control off always re-opens the transmitter
  assert_disable_opens_R9: assert property (@(posedge clk) disable iff (rst)
    !cfg_enable |=> tx_enable);
  // R10: events are exclusive and single-cycle
  assert_evt_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({evt_pause, evt_resume}));
  assert_evt_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    (evt_pause || evt_resume) |=> !(evt_pause || evt_resume));
endmodule

// File: rtl/swfc_emit.sv
module swfc_emit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         lane0_v,
  input  logic [W-1:0] lane0_d,
  input  logic         lane1_v,
  input  logic [W-1:0] lane1_d,
  output logic         fwd_valid,
  output logic [W-1:0] fwd_data
);
  logic         pend_v;
  logic [W-1:0] pend_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_valid <= 1'b0;
      fwd_data  <= '0;
      pend_v    <= 1'b0;
      pend_d    <= '0;
    end else if (lane0_v) begin
      fwd_valid <= 1'b1;
      fwd_data  <= lane0_d;
      pend_v    <= lane1_v;
      pend_d    <= lane1_d;
    end else if (pend_v) begin
      fwd_valid <= 1'b1;
      fwd_data  <= pend_d;
      pend_v    <= 1'b0;
    end else begin
      fwd_valid <= 1'b0;
    end
  end

  // R5: every forwarded byte comes from a lane or the pending slot
  assert_fwd_has_source_R5: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> $past(lane0_v || pend_v));
endmodule

// File: rtl/swfc_detect.sv
module swfc_detect
  import swfc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_enable,
  input  logic         cfg_double,
  input  logic         cfg_any_resume,
  input  logic [W-1:0] cfg_resume_a,
  input  logic [W-1:0] cfg_resume_b,
  input  logic [W-1:0] cfg_pause_a,
  input  logic [W-1:0] cfg_pause_b,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_data,
  input  logic         tx_boundary,
  output logic         tx_enable,
  output logic         fwd_valid,
  output logic [W-1:0] fwd_data,
  output logic         evt_pause,
  output logic         evt_resume
);
  hit_t         hit;
  logic         lane0_v, lane1_v, det_pause, det_resume;
  logic [W-1:0] lane0_d, lane1_d;

  swfc_match #(.W(W)) u_match (
    .byte_in(rx_data), .resume_a(cfg_resume_a), .resume_b(cfg_resume_b),
    .pause_a(cfg_pause_a), .pause_b(cfg_pause_b), .hit(hit)
  );

  swfc_seq #(.W(W)) u_seq (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_double(cfg_double),
    .rx_valid(rx_valid), .rx_data(rx_data), .hit(hit),
    .lane0_v(lane0_v), .lane0_d(lane0_d), .lane1_v(lane1_v), .lane1_d(lane1_d),
    .det_pause(det_pause), .det_resume(det_resume)
  );

  swfc_gate u_gate (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_any_resume(cfg_any_resume),
    .rx_valid(rx_valid), .det_pause(det_pause), .det_resume(det_resume),
    .tx_boundary(tx_boundary), .tx_enable(tx_enable),
    .evt_pause(evt_pause), .evt_resume(evt_resume)
  );

  swfc_emit #(.W(W)) u_emit (
    .clk(clk), .rst(rst), .lane0_v(lane0_v), .lane0_d(lane0_d),
    .lane1_v(lane1_v), .lane1_d(lane1_d),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data)
  );

  // R11: received-byte strobes are separated by at least one idle cycle
  assert_strobe_spacing_R11: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  // R4: a pause detection never coincides with a forwarded byte
  assert_pause_dropped_R4: assert property (@(posedge clk) disable iff (rst)
    evt_pause |-> !fwd_valid);
endmodule

// File: tb/swfc_detect_bench.sv
module swfc_detect_bench;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst, en, dbl, anyr, rxv, bnd;
  logic [W-1:0] ra, rb, pa, pb, rxd;
  logic txen, fv, ep, er;
  logic [W-1:0] fd;
  int checks = 0;
  int errors = 0;
  logic [W-1:0] expq[$];

  always #5 clk = ~clk;

  swfc_detect #(.W(W)) u_swfc_detect (
    .clk(clk), .rst(rst), .cfg_enable(en), .cfg_double(dbl), .cfg_any_resume(anyr),
    .cfg_resume_a(ra), .cfg_resume_b(rb), .cfg_pause_a(pa), .cfg_pause_b(pb),
    .rx_valid(rxv), .rx_data(rxd), .tx_boundary(bnd), .tx_enable(txen),
    .fwd_valid(fv), .fwd_data(fd), .evt_pause(ep), .evt_resume(er)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: every forwarded byte must match the next expected one
  always @(negedge clk) begin
    if (!rst && fv) begin
      if (expq.size() == 0) chk(1'b0, "R2/R5 unexpected forward", fd, 0);
      else begin
        logic [W-1:0] e;
        e = expq.pop_front();
        chk(fd == e, "R2/R5 forwarded byte", fd, e);
      end
    end
  end

  // Drive one byte; sample outputs one cycle after the strobe
  task automatic send(input logic [W-1:0] b, input logic xp, input logic xr, input string tag);
    @(negedge clk);
    rxv = 1'b1; rxd = b;
    @(negedge clk);
    rxv = 1'b0;
    chk(ep == xp, {tag, " evt_pause"}, ep, xp);
    chk(er == xr, {tag, " evt_resume"}, er, xr);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; en = 1'b0; dbl = 1'b0; anyr = 1'b0; rxv = 1'b0; rxd = '0; bnd = 1'b1;
    ra = 8'h11; rb = 8'h91; pa = 8'h13; pb = 8'h93;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    chk(txen == 1'b1, "R1 tx_enable", txen, 1);
    chk(fv == 1'b0, "R1 fwd_valid", fv, 0);
    chk(!ep && !er, "R1 events", {ep, er}, 0);

    // R2: disabled, patterns pass through
    expq.push_back(8'h13); send(8'h13, 0, 0, "R2");
    chk(txen == 1'b1, "R2 tx_enable", txen, 1);
    expq.push_back(8'h41); send(8'h41, 0, 0, "R2");

    // R3 single mode
    en = 1'b1;
    expq.push_back(8'h41); send(8'h41, 0, 0, "R3 data");
    expq.push_back(8'h93); send(8'h93, 0, 0, "R3 second pattern ignored");
    send(8'h13, 1, 0, "R3 pause");
    chk(txen == 1'b0, "R6 immediate boundary", txen, 0);
    expq.push_back(8'h42); send(8'h42, 0, 0, "R8 no any-resume");
    chk(txen == 1'b0, "R8 stays paused", txen, 0);
    send(8'h11, 0, 1, "R7 resume");
    chk(txen == 1'b1, "R7 tx_enable", txen, 1);

    // R6: wait for boundary
    bnd = 1'b0;
    send(8'h13, 1, 0, "R6 pause");
    chk(txen == 1'b1, "R6 mid-character", txen, 1);
    idle(2);
    chk(txen == 1'b1, "R6 still mid-character", txen, 1);
    bnd = 1'b1;
    @(negedge clk);
    chk(txen == 1'b0, "R6 at boundary", txen, 0);

    // R8: any-resume
    anyr = 1'b1;
    expq.push_back(8'h55); send(8'h55, 0, 0, "R8 any byte");
    chk(txen == 1'b1, "R8 resumed", txen, 1);
    anyr = 1'b0;

    // R3 priority: pause wins over equal resume pattern
    ra = 8'h13;
    send(8'h13, 1, 0, "R3 priority");
    ra = 8'h11;
    send(8'h11, 0, 1, "R3 resume after priority");

    // R4 double mode
    dbl = 1'b1;
    send(8'h13, 0, 0, "R4 first held");
    chk(fv == 1'b0, "R4 held not forwarded", fv, 0);
    send(8'h93, 1, 0, "R4 pause pair");
    chk(txen == 1'b0, "R4 paused", txen, 0);
    send(8'h11, 0, 0, "R4 resume first");
    send(8'h91, 0, 1, "R4 resume pair");
    chk(txen == 1'b1, "R4 resumed", txen, 1);

    // R5 broken pair
    send(8'h13, 0, 0, "R5 hold");
    expq.push_back(8'h13); expq.push_back(8'h44);
    send(8'h44, 0, 0, "R5 break");
    chk(fv && fd == 8'h13, "R5 held byte first", fd, 8'h13);
    @(negedge clk);
    chk(fv && fd == 8'h44, "R5 new byte next cycle", fd, 8'h44);
    send(8'h11, 0, 0, "R5 hold resume");
    expq.push_back(8'h11);
    send(8'h13, 0, 0, "R5 new first byte held");
    send(8'h93, 1, 0, "R5 pair after rehold");
    chk(txen == 1'b0, "R5 paused", txen, 0);

    // R9 disable clears hold and pause
    send(8'h11, 0, 0, "R9 hold");
    en = 1'b0;
    @(negedge clk);
    chk(txen == 1'b1, "R9 tx_enable", txen, 1);
    chk(fv == 1'b0, "R9 held discarded", fv, 0);
    expq.push_back(8'h91); send(8'h91, 0, 0, "R9 after disable");
    idle(3);

    chk(expq.size() == 0, "R5 scoreboard drained", expq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule